// File: doc/BRIEF.md
# Synthesizer Serial Register Loader

This block programs the three configuration registers of an integer-N frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a latch enable. A host presents a 14-bit reference divide value, a 16-bit total feedback divide ratio and a 12-bit function word, then pulses `start`. The block captures these values and builds three 21-bit frames. Each frame ends in a two-bit register address. The block shifts the frames out most significant bit first and raises latch enable after each frame so that the synthesizer commits it.

The feedback ratio is not sent as one number. The synthesizer counts in a divide-by-8 prescaler multiple and a swallow remainder. The block therefore sends the ratio shifted right by three as the multiple and its three low bits as the remainder, so that 8 × multiple + remainder equals the requested ratio. The serial clock is the system clock divided by `2*HALF_DIV`. While `busy` is high the block ignores `start`. A one-cycle `done` pulse marks the end of a load.

Top module: `synth_prog_loader`

## Requirements
- R1: After reset, and whenever no load is in progress, `busy`, `done`, `ser_clk`, `ser_le` and `ser_data` are all 0.
- R2: Each frame consists of exactly 21 rising edges of `ser_clk` before its latch pulse. The bit sampled at the first rising edge is frame bit 20 and the bit sampled at the last is frame bit 0.
- R3: Frame bits 1:0 hold the register address: 2'b10 for the function frame, 2'b00 for the reference frame and 2'b01 for the feedback frame.
- R4: A load sends exactly three frames, in this order: function, reference, feedback.
- R5: In the reference frame, bits 20:7 equal `ref_div` and bits 6:2 are zero.
- R6: In the feedback frame, bits 20:8 equal `fb_total >> 3`, bits 7:5 equal `fb_total[2:0]` and bits 4:2 are zero.
- R7: In the function frame, bits 20:9 equal `fn_bits` and bits 8:2 are zero. `fn_bits[2:0]` therefore lands in frame bits 11:9, the field that selects the synthesizer's test/lock output.
- R8: `ser_data` changes only while `ser_clk` is low, so it is stable at every rising edge and throughout each high phase.
- R9: During shifting, `ser_clk` is high for exactly `HALF_DIV` system clocks. Each rising edge is preceded by exactly `HALF_DIV` low cycles while `ser_le` is low.
- R10: `ser_le` is low while bits are shifted. After the 21st bit it is high for exactly `2*HALF_DIV` system clocks, and `ser_clk` stays low during that time.
- R11: `busy` goes high in the cycle after an accepted `start` and stays high until the last latch pulse ends. `done` is high for exactly one cycle: the first cycle in which that last `ser_le` is low. `busy` is low during that cycle.
- R12: The block samples the divide values and function word when it accepts `start`. A `start` pulse or an input change during a load has no effect on the frames sent and does not trigger a further load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load request, accepted only when idle |
| ref_div | input | 14 | Reference divide ratio |
| fb_total | input | 16 | Total feedback divide ratio |
| fn_bits | input | 12 | Function register payload |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch enable, high after each frame |

## Verification
The bench rebuilds every received frame from the serial pins and compares it with the expected frame.

- Ratios with nonzero and zero remainders, and all-ones and all-zero values, expose a wrong split of the feedback ratio. They also expose a wrong field placement, which would show up as a shifted or truncated field.
- A frame sent in the wrong order, or with a swapped address, shows up at the wrong slot in the received log.
- A `start` pulse and new input values injected mid-load catch two faults: a design that restarts, or one that reads its inputs live. The first would send a fourth frame and the second would corrupt the remaining frames.
- The monitor times every clock phase and latch pulse, and the `done` pulse relative to the falling edge of `ser_le`. These checks catch data changing while the clock is high, an off-by-one bit count and a misplaced `done`.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int FRAME_W    = 21;
    localparam int CTRL_W     = 2;
    localparam int PAYLOAD_W  = FRAME_W - CTRL_W;
    localparam int REF_W      = 14;
    localparam int FN_W       = 12;
    localparam int Z_W        = 3;
    localparam int N_W        = 13;
    localparam int TOTAL_W    = N_W + Z_W;
    localparam int NUM_FRAMES = 3;
    localparam int BIT_CNT_W  = $clog2(FRAME_W);
    localparam int FIDX_W     = $clog2(NUM_FRAMES);

    localparam int REF_PAD = PAYLOAD_W - REF_W;
    localparam int FB_PAD  = PAYLOAD_W - TOTAL_W;
    localparam int FN_PAD  = PAYLOAD_W - FN_W;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [CTRL_W-1:0] {
        SEL_REF = 2'b00,
        SEL_FB  = 2'b01,
        SEL_FN  = 2'b10
    } reg_sel_e;

    typedef struct packed {
        logic [REF_W-1:0]   ref_div;
        logic [TOTAL_W-1:0] fb_total;
        logic [FN_W-1:0]    fn_bits;
    } synth_cfg_t;

    typedef struct packed {
        logic [N_W-1:0] n_part;
        logic [Z_W-1:0] z_part;
    } fb_split_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_LATCH_A,
        ST_LATCH_B,
        ST_FINISH
    } seq_state_e;

    // Divide-by-8 prescaler multiple and swallow remainder.
    function automatic fb_split_t split_ratio(input logic [TOTAL_W-1:0] total);
        fb_split_t s;
        s.n_part = total[TOTAL_W-1:Z_W];
        s.z_part = total[Z_W-1:0];
        return s;
    endfunction

    // Transmission order: function, reference, feedback.
    function automatic reg_sel_e slot_sel(input int idx);
        case (idx)
            0:       return SEL_FN;
            1:       return SEL_REF;
            default: return SEL_FB;
        endcase
    endfunction

    function automatic frame_t build_frame(input synth_cfg_t cfg, input reg_sel_e sel);
        fb_split_t sp;
        frame_t    f;
        sp = split_ratio(cfg.fb_total);
        case (sel)
            SEL_REF: f = {cfg.ref_div, {REF_PAD{1'b0}}, sel};
            SEL_FB:  f = {sp.n_part, sp.z_part, {FB_PAD{1'b0}}, sel};
            SEL_FN:  f = {cfg.fn_bits, {FN_PAD{1'b0}}, sel};
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/sp_frame_asm.sv
module sp_frame_asm
    import synth_prog_pkg::*;
(
    input  synth_cfg_t        cfg,
    input  logic [FIDX_W-1:0] frame_idx,
    output frame_t            frame
);
    frame_t slot [NUM_FRAMES];

    generate
        for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_slot
            assign slot[g] = build_frame(cfg, slot_sel(g));
        end
    endgenerate

    always_comb begin
        if (int'(frame_idx) < NUM_FRAMES) begin
            frame = slot[frame_idx];
        end else begin
            frame = '0;
        end
    end
endmodule

// File: rtl/sp_shift_engine.sv
module sp_shift_engine
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  frame_t            cur_frame,
    output logic [FIDX_W-1:0] frame_idx,
    output logic              load,
    output logic              busy,
    output logic              done,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_W - 1);
    localparam logic [FIDX_W-1:0]    LAST_FR  = FIDX_W'(NUM_FRAMES - 1);

    seq_state_e           state;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BIT_CNT_W-1:0] bit_pos;
    logic                 in_bits;

    assign load = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            frame_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_BIT_LO;
                        bit_cnt   <= '0;
                        frame_idx <= '0;
                    end
                end
                ST_BIT_LO: begin
                    if (tick) state <= ST_BIT_HI;
                end
                ST_BIT_HI: begin
                    if (tick) begin
                        if (bit_cnt == LAST_BIT) begin
                            state <= ST_LATCH_A;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            state   <= ST_BIT_LO;
                        end
                    end
                end
                ST_LATCH_A: begin
                    if (tick) state <= ST_LATCH_B;
                end
                ST_LATCH_B: begin
                    if (tick) begin
                        if (frame_idx == LAST_FR) begin
                            state <= ST_FINISH;
                        end else begin
                            frame_idx <= frame_idx + 1'b1;
                            bit_cnt   <= '0;
                            state     <= ST_BIT_LO;
                        end
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign in_bits  = (state == ST_BIT_LO) || (state == ST_BIT_HI);
    assign bit_pos  = LAST_BIT - bit_cnt;
    assign ser_data = in_bits ? cur_frame[bit_pos] : 1'b0;
    assign ser_clk  = (state == ST_BIT_HI);
    assign ser_le   = (state == ST_LATCH_A) || (state == ST_LATCH_B);
    assign busy     = (state != ST_IDLE) && (state != ST_FINISH);
    assign done     = (state == ST_FINISH);
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
    import synth_prog_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [REF_W-1:0]   ref_div,
    input  logic [TOTAL_W-1:0] fb_total,
    input  logic [FN_W-1:0]    fn_bits,
    output logic               busy,
    output logic               done,
    output logic               ser_clk,
    output logic               ser_data,
    output logic               ser_le
);
    synth_cfg_t        cfg_q;
    frame_t            cur_frame;
    logic [FIDX_W-1:0] frame_idx;
    logic              load;
    logic              tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= '{ref_div: ref_div, fb_total: fb_total, fn_bits: fn_bits};
        end
    end

    sp_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .tick (tick)
    );

    sp_frame_asm u_asm (
        .cfg       (cfg_q),
        .frame_idx (frame_idx),
        .frame     (cur_frame)
    );

    sp_shift_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tick      (tick),
        .cur_frame (cur_frame),
        .frame_idx (frame_idx),
        .load      (load),
        .busy      (busy),
        .done      (done),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_le    (ser_le)
    );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
    parameter int HALF_DIV = 4,
    parameter int FRAME_W  = 21
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_le
);
    localparam int RC_W = $clog2(FRAME_W + 1) + 1;
    localparam int LC_W = $clog2(2 * HALF_DIV + 1) + 1;

    logic            prev_clk, prev_le;
    logic [RC_W-1:0] rises;
    logic [LC_W-1:0] le_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            prev_le  <= 1'b0;
            rises    <= '0;
            le_len   <= '0;
        end else begin
            prev_clk <= ser_clk;
            prev_le  <= ser_le;
            if (ser_le) rises <= '0;
            else if (ser_clk && !prev_clk) rises <= rises + 1'b1;
            if (ser_le) le_len <= le_len + 1'b1;
            else le_len <= '0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (!ser_clk && !ser_le));
    p_bit_count_r2: assert property (@(posedge clk) disable iff (rst)
        (ser_le && !prev_le) |-> (rises == RC_W'(FRAME_W)));
    p_data_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && prev_clk) |-> $stable(ser_data));
    p_le_width_r10: assert property (@(posedge clk) disable iff (rst)
        (!ser_le && prev_le) |-> (le_len == LC_W'(2 * HALF_DIV)));
    p_le_no_clk_r10: assert property (@(posedge clk) disable iff (rst)
        ser_le |-> !ser_clk);
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_le_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> (prev_le && !ser_le && !busy));
    p_start_accept_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start) |=> busy);
endmodule

bind synth_prog_loader sp_checker #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_le   (ser_le)
);

// File: tb/sim_synth_prog_loader.sv
module sim_synth_prog_loader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [13:0] ref_div = '0;
    logic [15:0] fb_total = '0;
    logic [11:0] fn_bits = '0;
    logic busy, done, ser_clk, ser_data, ser_le;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    synth_prog_loader #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .start(start), .ref_div(ref_div),
        .fb_total(fb_total), .fn_bits(fn_bits), .busy(busy), .done(done),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Serial monitor
    logic [20:0] cap = '0;
    logic [20:0] frame_log [64];
    int nbits_log [64];
    int fcount = 0, nbits = 0, hi_len = 0, lo_len = 0, le_len = 0, done_cnt = 0;
    logic prev_sclk = 0, prev_le = 0, prev_data = 0, prev_done = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = 0; prev_le = 0; prev_data = 0; prev_done = 0;
            nbits = 0; hi_len = 0; lo_len = 0; le_len = 0;
        end else begin
            if (ser_clk && !prev_sclk) begin
                chk(!ser_le, "R10 le low at clock rise", 32'(ser_le), 0);
                chk(lo_len == HALF, "R9 low phase length", lo_len, HALF);
                cap = {cap[19:0], ser_data};
                nbits++;
            end
            if (ser_clk && prev_sclk)
                chk(ser_data == prev_data, "R8 data stable while clock high", 32'(ser_data), 32'(prev_data));
            if (ser_clk) hi_len++;
            else begin
                if (prev_sclk) chk(hi_len == HALF, "R9 high phase length", hi_len, HALF);
                hi_len = 0;
            end
            if (!busy || ser_le || ser_clk) lo_len = 0;
            else lo_len++;
            if (ser_le && !prev_le) begin
                frame_log[fcount % 64] = cap;
                nbits_log[fcount % 64] = nbits;
                fcount++;
                nbits = 0;
            end
            if (ser_le) begin
                le_len++;
                chk(!ser_clk, "R10 clock low during latch", 32'(ser_clk), 0);
                chk(busy, "R11 busy during latch", 32'(busy), 1);
            end else begin
                if (prev_le) chk(le_len == 2 * HALF, "R10 latch width", le_len, 2 * HALF);
                le_len = 0;
            end
            if (done) begin
                done_cnt++;
                chk(prev_le && !ser_le, "R11 done follows final latch fall", {prev_le, ser_le}, 32'b10);
                chk(!busy, "R11 busy low with done", 32'(busy), 0);
                chk(!prev_done, "R11 done single cycle", 32'(prev_done), 0);
            end
            prev_sclk = ser_clk; prev_le = ser_le; prev_data = ser_data; prev_done = done;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog: actual hang expected completion");
            summary();
            $finish;
        end
    end

    function automatic logic [20:0] exp_fn(input logic [11:0] f);
        return {f, 7'b0, 2'b10};
    endfunction
    function automatic logic [20:0] exp_ref(input logic [13:0] r);
        return {r, 5'b0, 2'b00};
    endfunction
    function automatic logic [20:0] exp_fb(input logic [15:0] t);
        return {t[15:3], t[2:0], 3'b0, 2'b01};
    endfunction

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done(input int dbase);
        for (int i = 0; i < 5000 && done_cnt == dbase; i++) @(negedge clk);
        chk(done_cnt == dbase + 1, "R11 one done per load", done_cnt - dbase, 1);
    endtask

    task automatic check_frames(input int base, input logic [13:0] r, input logic [15:0] t, input logic [11:0] f);
        chk(fcount - base == 3, "R4 three frames per load", fcount - base, 3);
        for (int k = 0; k < 3; k++)
            chk(nbits_log[(base + k) % 64] == 21, "R2 bits per frame", nbits_log[(base + k) % 64], 21);
        chk(frame_log[base % 64] == exp_fn(f), "R7 R3 R4 function frame first",
            32'(frame_log[base % 64]), 32'(exp_fn(f)));
        chk(frame_log[(base + 1) % 64] == exp_ref(r), "R5 R3 R4 reference frame second",
            32'(frame_log[(base + 1) % 64]), 32'(exp_ref(r)));
        chk(frame_log[(base + 2) % 64] == exp_fb(t), "R6 R3 R4 feedback frame third",
            32'(frame_log[(base + 2) % 64]), 32'(exp_fb(t)));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({busy, done, ser_clk, ser_le, ser_data} == 5'b0, "R1 outputs quiet in reset",
            {busy, done, ser_clk, ser_le, ser_data}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy, done, ser_clk, ser_le, ser_data} == 5'b0, "R1 outputs quiet when idle",
            {busy, done, ser_clk, ser_le, ser_data}, 0);
    endtask

    task automatic t_load(input logic [13:0] r, input logic [15:0] t, input logic [11:0] f);
        int base = fcount;
        int dbase = done_cnt;
        ref_div = r; fb_total = t; fn_bits = f;
        pulse_start();
        chk(busy, "R11 busy after start", 32'(busy), 1);
        wait_done(dbase);
        repeat (2) @(negedge clk);
        chk(!busy, "R1 idle after load", 32'(busy), 0);
        check_frames(base, r, t, f);
    endtask

    task automatic t_ignore_busy();
        int base = fcount;
        int dbase = done_cnt;
        ref_div = 14'd1000; fb_total = 16'd2735; fn_bits = 12'h5A3;
        pulse_start();
        repeat (40) @(posedge clk);
        #1 ref_div = 14'h2AAA; fb_total = 16'hFFF8; fn_bits = 12'h00F;
        pulse_start();
        repeat (100) @(posedge clk);
        pulse_start();
        wait_done(dbase);
        check_frames(base, 14'd1000, 16'd2735, 12'h5A3);
        repeat (200) @(negedge clk);
        chk(fcount - base == 3, "R12 no extra load from start while busy", fcount - base, 3);
        chk(!busy, "R12 idle after ignored start", 32'(busy), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_load(14'd1000, 16'd2735, 12'h5A3);
        t_load(14'h3FFF, 16'hFFFF, 12'hFFF);
        t_load(14'd0, 16'd0, 12'h000);
        t_load(14'd651, 16'd2736, 12'h007);
        t_load(14'h1555, 16'h0005, 12'hA50);
        t_ignore_busy();
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule